// File: doc/BRIEF.md
# Banked GPIO Controller with Output Enables

This block drives and samples 64 general-purpose lines arranged as eight groups of eight. Two separate register ports reach it. A data port, decoded from an I/O window of eight consecutive addresses, holds one output-latch byte per group; reading it returns the live state of that group. A configuration port, addressed by an 8-bit index, holds one direction byte per group and, for the first five groups only, a function-select byte. The select byte marks which lines are handed to plain GPIO use.

Line n belongs to group n/8 and is bit n%8 inside it, and it appears on bit n of the pad vectors. Software changes one line by reading its group byte, changing the bit and writing the whole byte back. A line drives its pad when it is selected and its direction bit is 1. When its direction bit is 0, its data bit shows the pad level. An unselected line neither drives nor samples its pad. Groups 5 to 7 have no select byte and are always in GPIO use.

Top module: `gpio_bank_ctrl`

## Requirements
- R1: After reset all output latches, direction bits and select bits are 0, so pad_oe and pad_out are all 0, and both read-data outputs are 0x00.
- R2: Line n maps to group n/8, bit n%8, and appears on bit n of pad_out, pad_oe and pad_in.
- R3: A data-port write to address IO_BASE+g (g in 0..7) loads the latch byte of group g. Addresses outside IO_BASE..IO_BASE+7 leave every latch unchanged and read back 0x00.
- R4: The direction byte of group g is at configuration index 0xC8+g and reads back as written. Bit value 1 makes a selected line an output (pad_oe 1), and 0 makes it an input.
- R5: The select byte of group g is at index 0xC0+g only for g in 0..4 and reads back as written. Indices 0xC5..0xC7 hold no register: writes there are ignored and reads return 0x00. Lines of groups 5..7 are always selected.
- R6: A data-port read of group g returns, for each selected line, the latch bit if its direction bit is 1 and the pad_in bit if it is 0.
- R7: A line whose select bit is 0 has pad_oe 0 and reads as 0 through the data port, whatever its direction, latch and pad level.
- R8: Configuration indices outside 0xC0..0xC4 and 0xC8..0xCF read back as 0x00, and writes to them change nothing.
- R9: Read data on either port appears at the clock edge that samples the read strobe. It is then held unchanged until the next read on that port, even if pad_in changes.
- R10: A read-modify-write of one bit of a group byte changes only that line's output and leaves the other seven lines as they were.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| io_en | input | 1 | Data-port access strobe |
| io_we | input | 1 | Data-port write (1) or read (0) |
| io_addr | input | 16 | Data-port address |
| io_wdata | input | 8 | Data-port write byte |
| io_rdata | output | 8 | Data-port read byte (registered) |
| cfg_en | input | 1 | Configuration-port access strobe |
| cfg_we | input | 1 | Configuration-port write (1) or read (0) |
| cfg_idx | input | 8 | Configuration register index |
| cfg_wdata | input | 8 | Configuration write byte |
| cfg_rdata | output | 8 | Configuration read byte (registered) |
| pad_in | input | 64 | Pad input levels, bit n = line n |
| pad_out | output | 64 | Output latch value per line |
| pad_oe | output | 64 | Drive enable per line |

## Verification
A corrupted direction or select bit shows on pad_oe in the cycle after the write that should have set it. It also shows in the group's data-port read one cycle after the read strobe. A latch that is wrong, or that changed when it should not have, shows on pad_out at once. A wrong address window or index decode shows as a nonzero byte where 0x00 is due, or as a change on pad_out or pad_oe after a write that should have been ignored. The bench sweeps all 256 configuration indices, every line on its own, and several pad patterns against a model that it keeps itself, so such faults show within a few cycles of the access that caused them.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;
    localparam int          DEF_GROUPS     = 8;
    localparam int          DEF_GROUP_W    = 8;
    localparam int          DEF_SEL_GROUPS = 5;
    localparam int          DEF_IO_AW      = 16;
    localparam int          DEF_CFG_AW     = 8;
    localparam logic [15:0] DEF_IO_BASE    = 16'h0A00;
    localparam logic [7:0]  DEF_SEL_BASE   = 8'hC0;
    localparam logic [7:0]  DEF_OE_BASE    = 8'hC8;
endpackage

// File: rtl/gpio_bank_cfg.sv
module gpio_bank_cfg #(
    parameter int GROUPS     = 8,
    parameter int GW         = 8,
    parameter int SEL_GROUPS = 5,
    parameter int AW         = 8,
    parameter logic [AW-1:0] SEL_BASE = 8'hC0,
    parameter logic [AW-1:0] OE_BASE  = 8'hC8
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        cfg_en,
    input  logic                        cfg_we,
    input  logic [AW-1:0]               cfg_idx,
    input  logic [GW-1:0]               cfg_wdata,
    output logic [GW-1:0]               cfg_rdata,
    output logic [GROUPS-1:0][GW-1:0]   oe,
    output logic [GROUPS-1:0][GW-1:0]   active
);
    localparam int GIW = $clog2(GROUPS);
    localparam int SIW = $clog2(SEL_GROUPS);

    typedef struct packed {
        logic [GROUPS-1:0][GW-1:0]     oe;
        logic [SEL_GROUPS-1:0][GW-1:0] sel;
        logic [GW-1:0]                 rdata;
    } cfg_state_t;

    cfg_state_t st_d, st_q;
    logic [AW-1:0]  oe_off, sel_off;
    logic           oe_hit, sel_hit;
    logic [GIW-1:0] oe_g;
    logic [SIW-1:0] sel_g;

    always_comb begin
        oe_off  = cfg_idx - OE_BASE;
        sel_off = cfg_idx - SEL_BASE;
        oe_hit  = oe_off < AW'(GROUPS);
        sel_hit = sel_off < AW'(SEL_GROUPS);
        oe_g    = oe_off[GIW-1:0];
        sel_g   = sel_off[SIW-1:0];
        st_d    = st_q;
        if (cfg_en) begin
            if (cfg_we) begin
                if (oe_hit)
                    st_d.oe[oe_g] = cfg_wdata;
                else if (sel_hit)
                    st_d.sel[sel_g] = cfg_wdata;
            end else begin
                st_d.rdata = '0;
                if (oe_hit)
                    st_d.rdata = st_q.oe[oe_g];
                else if (sel_hit)
                    st_d.rdata = st_q.sel[sel_g];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign cfg_rdata = st_q.rdata;
    assign oe        = st_q.oe;

    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        if (g < SEL_GROUPS) begin : g_sel
            assign active[g] = st_q.sel[g];

            assert_sel_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
                !(cfg_en && cfg_we && cfg_idx == SEL_BASE + AW'(g)) |=> $stable(active[g]));
        end else begin : g_fixed
            assign active[g] = '1;
        end

        assert_oe_write_R4: assert property (@(posedge clk) disable iff (!rst_n)
            (cfg_en && cfg_we && cfg_idx == OE_BASE + AW'(g)) |=> (oe[g] == $past(cfg_wdata)));
    end

    assert_cfg_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(cfg_en && !cfg_we) |=> $stable(cfg_rdata));

    assert_unmapped_zero_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_en && !cfg_we && !oe_hit && !sel_hit) |=> (cfg_rdata == '0));
endmodule

// File: rtl/gpio_bank_data.sv
module gpio_bank_data #(
    parameter int GROUPS = 8,
    parameter int GW     = 8,
    parameter int AW     = 16,
    parameter logic [AW-1:0] IO_BASE = 16'h0A00
) (
    input  logic                      clk,
    input  logic                      rst_n,
    input  logic                      io_en,
    input  logic                      io_we,
    input  logic [AW-1:0]             io_addr,
    input  logic [GW-1:0]             io_wdata,
    output logic [GW-1:0]             io_rdata,
    input  logic [GROUPS-1:0][GW-1:0] rd_view,
    output logic [GROUPS-1:0][GW-1:0] latch
);
    localparam int GIW = $clog2(GROUPS);

    typedef struct packed {
        logic [GROUPS-1:0][GW-1:0] latch;
        logic [GW-1:0]             rdata;
    } data_state_t;

    data_state_t    st_d, st_q;
    logic [AW-1:0]  io_off;
    logic           io_hit;
    logic [GIW-1:0] io_g;

    always_comb begin
        io_off = io_addr - IO_BASE;
        io_hit = io_off < AW'(GROUPS);
        io_g   = io_off[GIW-1:0];
        st_d   = st_q;
        if (io_en) begin
            if (io_we) begin
                if (io_hit) st_d.latch[io_g] = io_wdata;
            end else begin
                st_d.rdata = io_hit ? rd_view[io_g] : '0;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign io_rdata = st_q.rdata;
    assign latch    = st_q.latch;

    assert_latch_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_en && io_we && io_hit) |=> $stable(latch));

    assert_io_miss_zero_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (io_en && !io_we && !io_hit) |=> (io_rdata == '0));

    assert_io_rd_hold_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(io_en && !io_we) |=> $stable(io_rdata));
endmodule

// File: rtl/gpio_bank_padmux.sv
module gpio_bank_padmux #(
    parameter int GROUPS = 8,
    parameter int GW     = 8
) (
    input  logic [GROUPS-1:0][GW-1:0] oe,
    input  logic [GROUPS-1:0][GW-1:0] active,
    input  logic [GROUPS-1:0][GW-1:0] latch,
    input  logic [GROUPS-1:0][GW-1:0] pin,
    output logic [GROUPS-1:0][GW-1:0] drv_en,
    output logic [GROUPS-1:0][GW-1:0] drv_val,
    output logic [GROUPS-1:0][GW-1:0] rd_view
);
    for (genvar g = 0; g < GROUPS; g++) begin : g_grp
        for (genvar b = 0; b < GW; b++) begin : g_bit
            assign drv_en[g][b]  = active[g][b] & oe[g][b];
            assign drv_val[g][b] = latch[g][b];
            assign rd_view[g][b] = active[g][b] & (oe[g][b] ? latch[g][b] : pin[g][b]);
        end
    end
endmodule

// File: rtl/gpio_bank_ctrl.sv
module gpio_bank_ctrl
    import gpio_bank_pkg::*;
#(
    parameter int GROUPS     = DEF_GROUPS,
    parameter int GW         = DEF_GROUP_W,
    parameter int SEL_GROUPS = DEF_SEL_GROUPS,
    parameter int IO_AW      = DEF_IO_AW,
    parameter int CFG_AW     = DEF_CFG_AW,
    parameter logic [IO_AW-1:0]  IO_BASE  = DEF_IO_BASE,
    parameter logic [CFG_AW-1:0] SEL_BASE = DEF_SEL_BASE,
    parameter logic [CFG_AW-1:0] OE_BASE  = DEF_OE_BASE,
    localparam int LINES = GROUPS * GW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              io_en,
    input  logic              io_we,
    input  logic [IO_AW-1:0]  io_addr,
    input  logic [GW-1:0]     io_wdata,
    output logic [GW-1:0]     io_rdata,
    input  logic              cfg_en,
    input  logic              cfg_we,
    input  logic [CFG_AW-1:0] cfg_idx,
    input  logic [GW-1:0]     cfg_wdata,
    output logic [GW-1:0]     cfg_rdata,
    input  logic [LINES-1:0]  pad_in,
    output logic [LINES-1:0]  pad_out,
    output logic [LINES-1:0]  pad_oe
);
    logic [GROUPS-1:0][GW-1:0] oe_w, active_w, latch_w, pin_w;
    logic [GROUPS-1:0][GW-1:0] drv_en_w, drv_val_w, rd_view_w;

    assign pin_w   = pad_in;
    assign pad_oe  = drv_en_w;
    assign pad_out = drv_val_w;

    gpio_bank_cfg #(
        .GROUPS(GROUPS), .GW(GW), .SEL_GROUPS(SEL_GROUPS), .AW(CFG_AW),
        .SEL_BASE(SEL_BASE), .OE_BASE(OE_BASE)
    ) u_cfg (
        .clk(clk), .rst_n(rst_n), .cfg_en(cfg_en), .cfg_we(cfg_we),
        .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .oe(oe_w), .active(active_w)
    );

    gpio_bank_data #(
        .GROUPS(GROUPS), .GW(GW), .AW(IO_AW), .IO_BASE(IO_BASE)
    ) u_data (
        .clk(clk), .rst_n(rst_n), .io_en(io_en), .io_we(io_we),
        .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .rd_view(rd_view_w), .latch(latch_w)
    );

    gpio_bank_padmux #(
        .GROUPS(GROUPS), .GW(GW)
    ) u_mux (
        .oe(oe_w), .active(active_w), .latch(latch_w), .pin(pin_w),
        .drv_en(drv_en_w), .drv_val(drv_val_w), .rd_view(rd_view_w)
    );

    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (pad_oe == '0 && pad_out == '0 && io_rdata == '0 && cfg_rdata == '0));

    assert_inactive_quiet_R7: assert property (@(posedge clk) disable iff (!rst_n)
        ((pad_oe & ~active_w) == '0));
endmodule

// File: tb/tb_gpio_bank_ctrl.sv
module tb_gpio_bank_ctrl;
    localparam logic [15:0] BASE = 16'h0A00;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        io_en = 1'b0, io_we = 1'b0;
    logic [15:0] io_addr = '0;
    logic [7:0]  io_wdata = '0;
    logic [7:0]  io_rdata;
    logic        cfg_en = 1'b0, cfg_we = 1'b0;
    logic [7:0]  cfg_idx = '0, cfg_wdata = '0;
    logic [7:0]  cfg_rdata;
    logic [63:0] pad_in = '0;
    logic [63:0] pad_out, pad_oe;

    int checks = 0;
    int errors = 0;

    logic [7:0] m_sel [5];
    logic [7:0] m_oe  [8];
    logic [7:0] m_lat [8];

    always #10 clk = ~clk;

    gpio_bank_ctrl dut (
        .clk(clk), .rst_n(rst_n),
        .io_en(io_en), .io_we(io_we), .io_addr(io_addr), .io_wdata(io_wdata), .io_rdata(io_rdata),
        .cfg_en(cfg_en), .cfg_we(cfg_we), .cfg_idx(cfg_idx), .cfg_wdata(cfg_wdata), .cfg_rdata(cfg_rdata),
        .pad_in(pad_in), .pad_out(pad_out), .pad_oe(pad_oe)
    );

    function automatic logic [7:0] act(int g);
        return (g < 5) ? m_sel[g] : 8'hFF;
    endfunction

    function automatic logic [7:0] exp_rd(int g);
        return act(g) & ((m_oe[g] & m_lat[g]) | (~m_oe[g] & pad_in[g*8 +: 8]));
    endfunction

    function automatic logic [63:0] exp_oe();
        logic [63:0] r;
        for (int g = 0; g < 8; g++) r[g*8 +: 8] = m_oe[g] & act(g);
        return r;
    endfunction

    function automatic logic [63:0] exp_out();
        logic [63:0] r;
        for (int g = 0; g < 8; g++) r[g*8 +: 8] = m_lat[g];
        return r;
    endfunction

    function automatic logic [7:0] exp_cfg(int i);
        if (i >= 8'hC8 && i <= 8'hCF) return m_oe[i - 8'hC8];
        if (i >= 8'hC0 && i <= 8'hC4) return m_sel[i - 8'hC0];
        return 8'h00;
    endfunction

    task automatic chk(input string req, input logic [63:0] got, input logic [63:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got=%h expected=%h", req, got, exp);
        end
    endtask

    task automatic io_wr(input logic [15:0] a, input logic [7:0] d);
        logic [15:0] off;
        @(negedge clk);
        io_en = 1'b1; io_we = 1'b1; io_addr = a; io_wdata = d;
        @(negedge clk);
        io_en = 1'b0; io_we = 1'b0;
        off = a - BASE;
        if (off < 16'd8) m_lat[off[2:0]] = d;
    endtask

    task automatic io_rd(input logic [15:0] a, output logic [7:0] d);
        @(negedge clk);
        io_en = 1'b1; io_we = 1'b0; io_addr = a;
        @(negedge clk);
        io_en = 1'b0;
        d = io_rdata;
    endtask

    task automatic cfg_wr(input logic [7:0] i, input logic [7:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b1; cfg_idx = i; cfg_wdata = d;
        @(negedge clk);
        cfg_en = 1'b0; cfg_we = 1'b0;
        if (i >= 8'hC8 && i <= 8'hCF) m_oe[i - 8'hC8] = d;
        else if (i >= 8'hC0 && i <= 8'hC4) m_sel[i - 8'hC0] = d;
    endtask

    task automatic cfg_rd(input logic [7:0] i, output logic [7:0] d);
        @(negedge clk);
        cfg_en = 1'b1; cfg_we = 1'b0; cfg_idx = i;
        @(negedge clk);
        cfg_en = 1'b0;
        d = cfg_rdata;
    endtask

    task automatic sweep_cfg(input string req);
        logic [7:0] d;
        for (int i = 0; i < 256; i++) begin
            cfg_rd(8'(i), d);
            chk(req, {56'd0, d}, {56'd0, exp_cfg(i)});
        end
    endtask

    task automatic sweep_data(input string req);
        logic [7:0] d;
        for (int g = 0; g < 8; g++) begin
            io_rd(BASE + 16'(g), d);
            chk(req, {56'd0, d}, {56'd0, exp_rd(g)});
        end
    endtask

    task automatic chk_pads(input string req);
        chk({req, " pad_oe"}, pad_oe, exp_oe());
        chk({req, " pad_out"}, pad_out, exp_out());
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0]  d, d0;
        logic [63:0] pats [3];
        pats[0] = 64'hA5A5_3C3C_0F0F_F0F0;
        pats[1] = 64'h1234_5678_9ABC_DEF0;
        pats[2] = 64'hFFFF_0000_5555_AAAA;
        for (int g = 0; g < 8; g++) begin m_oe[g] = 0; m_lat[g] = 0; end
        for (int g = 0; g < 5; g++) m_sel[g] = 0;
        pad_in = pats[0];
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state at the ports
        chk("R1 pad_oe", pad_oe, 64'd0);
        chk("R1 pad_out", pad_out, 64'd0);
        chk("R1 io_rdata", {56'd0, io_rdata}, 64'd0);
        chk("R1 cfg_rdata", {56'd0, cfg_rdata}, 64'd0);
        sweep_cfg("R1 R8 cfg after reset");
        // R7: groups 0..4 unselected read 0; R5 groups 5..7 follow the pads
        sweep_data("R7 R5 data after reset");

        // R5 select writes, ignored holes; R8 ignored writes elsewhere
        for (int g = 0; g < 5; g++) cfg_wr(8'hC0 + 8'(g), 8'hFF);
        cfg_wr(8'hC5, 8'hFF); cfg_wr(8'hC6, 8'h5A); cfg_wr(8'hC7, 8'h81);
        cfg_wr(8'h00, 8'hFF); cfg_wr(8'hBF, 8'hFF); cfg_wr(8'hD0, 8'hFF);
        chk_pads("R8 after ignored writes");
        sweep_cfg("R5 R8 cfg sweep");

        // R4 R6 direction and latch patterns under several pad patterns
        for (int g = 0; g < 8; g++) begin
            cfg_wr(8'hC8 + 8'(g), 8'(g * 8'h11) ^ 8'h5A);
            io_wr(BASE + 16'(g), 8'(g * 8'h23) ^ 8'hC3);
        end
        chk_pads("R4");
        sweep_cfg("R4 cfg sweep");
        for (int p = 0; p < 3; p++) begin
            pad_in = pats[p];
            sweep_data("R6 mixed directions");
        end

        // R2: each line alone, all outputs
        for (int g = 0; g < 8; g++) cfg_wr(8'hC8 + 8'(g), 8'hFF);
        for (int g = 0; g < 8; g++) io_wr(BASE + 16'(g), 8'h00);
        for (int n = 0; n < 64; n++) begin
            io_wr(BASE + 16'(n / 8), 8'(1 << (n % 8)));
            chk("R2 single line", pad_out, 64'd1 << n);
            chk("R2 pad_oe all", pad_oe, {64{1'b1}});
            io_wr(BASE + 16'(n / 8), 8'h00);
        end

        // R3: writes outside the window change nothing and read 0
        for (int g = 0; g < 8; g++) io_wr(BASE + 16'(g), 8'(8'h19 * g + 1));
        io_wr(BASE - 16'd1, 8'hFF);
        io_wr(BASE + 16'd8, 8'hFF);
        io_wr(16'h0000, 8'hFF);
        chk_pads("R3 out-of-window write");
        io_rd(BASE - 16'd1, d);
        chk("R3 read below window", {56'd0, d}, 64'd0);
        io_rd(BASE + 16'd8, d);
        chk("R3 read above window", {56'd0, d}, 64'd0);

        // R10: read-modify-write of bit 5 in group 3
        io_rd(BASE + 16'd3, d);
        chk("R10 read before rmw", {56'd0, d}, {56'd0, m_lat[3]});
        io_wr(BASE + 16'd3, d | 8'h20);
        chk("R10 set bit", pad_out, exp_out());
        chk("R10 bit 29 high", {63'd0, pad_out[29]}, 64'd1);
        io_rd(BASE + 16'd3, d);
        io_wr(BASE + 16'd3, d & ~8'h20);
        chk("R10 clear bit", pad_out, exp_out());

        // R7: partial select on group 2 hides the upper nibble
        cfg_wr(8'hC2, 8'h0F);
        cfg_wr(8'hCA, 8'hC3);
        io_wr(BASE + 16'd2, 8'hFF);
        pad_in = 64'hFFFF_FFFF_FFFF_FFFF;
        chk_pads("R7 partial select");
        chk("R7 upper nibble quiet", {56'd0, pad_oe[23:16]}, 64'h03);
        io_rd(BASE + 16'd2, d);
        chk("R7 unselected bits read 0", {56'd0, d}, 64'h0F);
        cfg_wr(8'hC1, 8'h00);
        io_rd(BASE + 16'd1, d);
        chk("R7 whole group unselected", {56'd0, d}, 64'h00);

        // R9: held read data
        cfg_wr(8'hCE, 8'h00);
        pad_in[55:48] = 8'h96;
        io_rd(BASE + 16'd6, d0);
        chk("R9 first read", {56'd0, d0}, 64'h96);
        pad_in[55:48] = 8'h3C;
        repeat (3) @(negedge clk);
        chk("R9 io_rdata held", {56'd0, io_rdata}, 64'h96);
        cfg_rd(8'hCE, d);
        pad_in[55:48] = 8'h11;
        repeat (2) @(negedge clk);
        chk("R9 cfg_rdata held", {56'd0, cfg_rdata}, 64'h00);
        chk("R9 io_rdata held after cfg read", {56'd0, io_rdata}, 64'h96);
        io_rd(BASE + 16'd6, d);
        chk("R9 new read", {56'd0, d}, 64'h11);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule